// File: doc/BRIEF.md
# Hot List Ring Buffer

This block keeps a circular list of hot-region records for a memory hotness monitor. A tracking engine writes a unit index and an access count on the write port. The block packs the two values into one 64-bit record and appends the record at the tail of the ring.

The width of the count field is a register input. The count sits in the low bits of the record and the unit index fills every bit above it. Software gets a device address by multiplying the unit index by the configured tracking unit size. A coarser unit needs fewer index bits, which leaves room for a wider count.

A host reads the oldest record from the read port and pops it to move on to the next one. The host can see the current fill level at all times. The block drives two interrupt lines. One is a level interrupt that stays high while occupancy is above a programmable watermark. The other is a sticky overflow flag, set when a record arrives while the ring is full and cleared by a write-one-to-clear pulse.

Top module: `hot_list_ring`

## Requirements
- R1: After reset the ring is empty: `rd_valid` is 0, `fill_level` is 0, `rd_entry` is 0, and both interrupts are low.
- R2: A stored record equals (unit << cw) | count, where cw is the effective count width. The count occupies bits [cw-1:0], and unit bits that would land above bit 63 are discarded.
- R3: A count larger than 2^cw - 1 is stored as 2^cw - 1, which is all ones in the count field.
- R4: The effective count width is `cfg_cnt_width` clamped to the range 8 to 32. The width is sampled in the cycle of the write.
- R5: Records are read in the order they were written. `rd_entry` shows the oldest record, and a pop while `rd_valid` is high removes that record. `rd_entry` is 0 while the ring is empty.
- R6: `fill_level` equals the number of stored records, from 0 up to DEPTH. A write accepted without a pop raises it by one.
- R7: A pop while the ring is empty is ignored, and the fill level stays 0.
- R8: A write that arrives while the ring is full at the start of that cycle is dropped and leaves the contents unchanged. This holds even if a pop occurs in the same cycle; the pop itself still takes effect.
- R9: `irq_ovf` is set by a dropped write and stays set until an `ovf_clear` pulse. If a drop and a clear occur in the same cycle, the flag stays set.
- R10: `irq_wm` is high exactly while `fill_level` is greater than `cfg_watermark`.
- R11: Every effect of a write, pop or clear is visible on the outputs in the cycle that follows the clock edge on which it was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cnt_width | input | 6 | Requested count field width (clamped to 8..32) |
| cfg_watermark | input | PTR_W+1 | Occupancy threshold for `irq_wm` |
| wr_valid | input | 1 | Write a record this cycle |
| wr_unit | input | 56 | Unit index of the record |
| wr_count | input | 32 | Access count of the record |
| rd_pop | input | 1 | Consume the head record |
| ovf_clear | input | 1 | Write-one-to-clear for the overflow flag |
| rd_entry | output | 64 | Head record (0 when empty) |
| rd_valid | output | 1 | Ring holds at least one record |
| fill_level | output | PTR_W+1 | Number of stored records |
| irq_wm | output | 1 | Occupancy above the watermark |
| irq_ovf | output | 1 | Sticky overflow flag |

## Verification
Every result is due one clock edge after its stimulus. This covers a newly written head record, a pop that exposes the next record, the new fill level, the watermark level change, and the set or clear of the overflow flag. Each result is therefore on the outputs by the falling edge that follows. The bench drives inputs at a falling edge and advances a queue-based model as the next rising edge will. It compares every output at the following falling edge, so the model and the design are always checked in the same cycle. The boundary cases are checked the same way:
- full with a pop in the same cycle,
- empty with a pop,
- drop and clear in the same cycle,
- out-of-range count widths.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int ENTRY_W = 64;
  localparam int CW_MIN  = 8;
  localparam int CW_MAX  = 32;
  localparam int CW_BITS = 6;
  localparam int UNIT_W  = ENTRY_W - CW_MIN;

  typedef logic [ENTRY_W-1:0] entry_t;

  // Clamp a requested count width into the legal range.
  function automatic logic [CW_BITS-1:0] clamp_cw(input logic [CW_BITS-1:0] req);
    if (req < CW_BITS'(CW_MIN)) return CW_BITS'(CW_MIN);
    if (req > CW_BITS'(CW_MAX)) return CW_BITS'(CW_MAX);
    return req;
  endfunction

  // Saturate the count to the field, then place the unit index above it.
  function automatic entry_t pack_entry(input logic [UNIT_W-1:0] unit,
                                        input logic [CW_MAX-1:0] cnt,
                                        input logic [CW_BITS-1:0] cw);
    logic [ENTRY_W-1:0] lim_w;
    logic [CW_MAX-1:0]  lim;
    logic [ENTRY_W-1:0] cnt_f;
    logic [ENTRY_W-1:0] unit_f;
    lim_w  = (ENTRY_W'(1) << cw) - ENTRY_W'(1);
    lim    = lim_w[CW_MAX-1:0];
    cnt_f  = ENTRY_W'((cnt > lim) ? lim : cnt);
    unit_f = ENTRY_W'(unit) << cw;
    return unit_f | cnt_f;
  endfunction
endpackage

// File: rtl/hl_packer.sv
module hl_packer
  import hl_pkg::*;
(
  input  logic [UNIT_W-1:0]  unit,
  input  logic [CW_MAX-1:0]  count,
  input  logic [CW_BITS-1:0] cfg_cw,
  output entry_t             entry
);
  logic [CW_BITS-1:0] eff_cw;

  always_comb begin
    eff_cw = clamp_cw(cfg_cw);
    entry  = pack_entry(unit, count, eff_cw);
  end

  // R4: the effective width never leaves the legal range.
  always_comb begin
    a_r4_cw_range: assert (eff_cw >= CW_BITS'(CW_MIN) && eff_cw <= CW_BITS'(CW_MAX));
  end
endmodule

// File: rtl/hl_store.sv
module hl_store
  import hl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  entry_t           wdata,
  input  logic [PTR_W-1:0] raddr,
  output entry_t           rdata
);
  entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hl_ptrs.sv
module hl_ptrs #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             pop,
  input  logic             ovf_clear,
  input  logic [PTR_W:0]   watermark,
  output logic             wr_acc,
  output logic             empty,
  output logic [PTR_W-1:0] waddr,
  output logic [PTR_W-1:0] raddr,
  output logic [PTR_W:0]   fill,
  output logic             irq_wm,
  output logic             irq_ovf
);
  logic [PTR_W:0] head_q, tail_q;
  logic           full, drop, pop_acc, ovf_q;

  assign empty   = (head_q == tail_q);
  assign full    = (head_q[PTR_W] != tail_q[PTR_W]) &&
                   (head_q[PTR_W-1:0] == tail_q[PTR_W-1:0]);
  assign wr_acc  = wr_valid && !full;
  assign drop    = wr_valid && full;
  assign pop_acc = pop && !empty;
  assign waddr   = tail_q[PTR_W-1:0];
  assign raddr   = head_q[PTR_W-1:0];
  assign fill    = tail_q - head_q;
  assign irq_wm  = (fill > watermark);
  assign irq_ovf = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_acc)  tail_q <= tail_q + 1'b1;
      if (pop_acc) head_q <= head_q + 1'b1;
      if (drop)           ovf_q <= 1'b1;
      else if (ovf_clear) ovf_q <= 1'b0;
    end
  end

  // R6: occupancy bound
  always_comb begin
    if (rst_n) a_r6_fill_bound: assert (fill <= (PTR_W+1)'(DEPTH));
  end

  a_r6_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !pop_acc) |=> (fill == $past(fill) + 1'b1));

  a_r8_drop_keeps_tail: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(tail_q));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(head_q));

  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> irq_ovf);

  a_r9_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && !ovf_clear) |=> irq_ovf);
endmodule

// File: rtl/hot_list_ring.sv
module hot_list_ring
  import hl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW_BITS-1:0]  cfg_cnt_width,
  input  logic [PTR_W:0]      cfg_watermark,
  input  logic                wr_valid,
  input  logic [UNIT_W-1:0]   wr_unit,
  input  logic [CW_MAX-1:0]   wr_count,
  input  logic                rd_pop,
  input  logic                ovf_clear,
  output logic [ENTRY_W-1:0]  rd_entry,
  output logic                rd_valid,
  output logic [PTR_W:0]      fill_level,
  output logic                irq_wm,
  output logic                irq_ovf
);
  entry_t           packed_e, head_e;
  logic             wr_acc, empty;
  logic [PTR_W-1:0] waddr, raddr;

  hl_packer u_packer (
    .unit(wr_unit), .count(wr_count), .cfg_cw(cfg_cnt_width), .entry(packed_e)
  );

  hl_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .pop(rd_pop),
    .ovf_clear(ovf_clear), .watermark(cfg_watermark), .wr_acc(wr_acc),
    .empty(empty), .waddr(waddr), .raddr(raddr), .fill(fill_level),
    .irq_wm(irq_wm), .irq_ovf(irq_ovf)
  );

  hl_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_acc), .waddr(waddr), .wdata(packed_e),
    .raddr(raddr), .rdata(head_e)
  );

  assign rd_valid = !empty;
  assign rd_entry = empty ? '0 : head_e;

  // R5: the head record is only exposed while the ring holds data.
  always_comb begin
    if (rst_n && empty) a_r5_empty_zero: assert (rd_entry == '0);
  end
endmodule

// File: tb/test_hot_list_ring.sv
module test_hot_list_ring;
  localparam int DEPTH = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  cfg_cnt_width = 6'd16;
  logic [4:0]  cfg_watermark = 5'd4;
  logic        wr_valid = 0;
  logic [55:0] wr_unit = '0;
  logic [31:0] wr_count = '0;
  logic        rd_pop = 0;
  logic        ovf_clear = 0;
  logic [63:0] rd_entry;
  logic        rd_valid;
  logic [4:0]  fill_level;
  logic        irq_wm;
  logic        irq_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  logic [63:0] model_q[$];
  bit model_ovf = 0;

  always #10 clk = ~clk;

  hot_list_ring #(.DEPTH(DEPTH)) i_hot_list_ring (
    .clk(clk), .rst_n(rst_n), .cfg_cnt_width(cfg_cnt_width),
    .cfg_watermark(cfg_watermark), .wr_valid(wr_valid), .wr_unit(wr_unit),
    .wr_count(wr_count), .rd_pop(rd_pop), .ovf_clear(ovf_clear),
    .rd_entry(rd_entry), .rd_valid(rd_valid), .fill_level(fill_level),
    .irq_wm(irq_wm), .irq_ovf(irq_ovf)
  );

  // Reference packing built bit by bit from the requirement text.
  function automatic logic [63:0] ref_pack(input logic [55:0] u, input logic [31:0] c,
                                           input int req_cw);
    logic [63:0] e = '0;
    int cw = (req_cw < 8) ? 8 : (req_cw > 32) ? 32 : req_cw;
    longint unsigned maxc = (64'd1 << cw) - 1;
    longint unsigned cv = (longint'(c) > maxc) ? maxc : longint'(c);
    for (int i = 0; i < cw; i++) e[i] = cv[i];
    for (int i = 0; i < 56; i++) if (i + cw < 64) e[i + cw] = u[i];
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] head = (model_q.size() > 0) ? model_q[0] : 64'd0;
    check("R5 rd_valid", 64'(rd_valid), 64'(model_q.size() > 0));
    check("R5/R2 rd_entry", rd_entry, head);
    check("R6 fill_level", 64'(fill_level), 64'(model_q.size()));
    check("R10 irq_wm", 64'(irq_wm), 64'(model_q.size() > int'(cfg_watermark)));
    check("R9 irq_ovf", 64'(irq_ovf), 64'(model_ovf));
  endtask

  // Drive one cycle at a falling edge, advance the model, compare at the next falling edge (R11).
  task automatic step(input bit wv, input logic [55:0] u, input logic [31:0] c,
                      input bit pop, input bit clr);
    bit was_full = (model_q.size() == DEPTH);
    wr_valid = wv; wr_unit = u; wr_count = c; rd_pop = pop; ovf_clear = clr;
    if (pop && model_q.size() > 0) void'(model_q.pop_front());
    if (wv) begin
      if (was_full) model_ovf = 1;
      else model_q.push_back(ref_pack(u, c, int'(cfg_cnt_width)));
    end
    if (clr && !(wv && was_full)) model_ovf = 0;
    @(negedge clk);
    wr_valid = 0; rd_pop = 0; ovf_clear = 0;
    compare_all();
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    compare_all();

    phase = "R2";
    step(1, 56'h12, 32'h0283, 0, 0);
    step(1, 56'hAB_CDEF_0123_4567, 32'h1234, 0, 0);
    step(1, 56'h7, 32'h0, 0, 0);
    phase = "R5";
    step(0, 0, 0, 1, 0);
    step(1, 56'h99, 32'h55, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);

    phase = "R3";
    cfg_cnt_width = 6'd8;
    step(1, 56'h3, 32'h1FF, 0, 0);
    cfg_cnt_width = 6'd32;
    step(1, 56'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    phase = "R4";
    cfg_cnt_width = 6'd3;
    step(1, 56'h5, 32'h3FF, 0, 0);
    cfg_cnt_width = 6'd40;
    step(1, 56'h5, 32'h8000_0001, 0, 0);
    cfg_cnt_width = 6'd12;

    phase = "R10";
    while (model_q.size() < DEPTH) step(1, 56'(model_q.size() * 3), 32'(model_q.size()), 0, 0);

    phase = "R8";
    step(1, 56'hDEAD, 32'h1, 0, 0);
    step(0, 0, 0, 0, 1);
    step(1, 56'hBEEF, 32'h2, 1, 0);
    phase = "R9";
    step(0, 0, 0, 0, 0);
    step(1, 56'h1, 32'h1, 0, 0);
    step(1, 56'h2, 32'h2, 0, 1);
    step(0, 0, 0, 0, 1);

    phase = "R7";
    cfg_watermark = 5'd10;
    while (model_q.size() > 0) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(1, 56'h42, 32'h42, 1, 0);
    step(0, 0, 0, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule